// File: doc/BRIEF.md
# Serial Flash Controller Byte-Transfer Port

This block is the software-driven side of a serial flash controller: a memory-mapped SPI master that moves one byte at a time. Software writes a small register file over a simple 32-bit word port. It sets a control bit to take ownership of the serial bus and drives the chip select through another control bit. It then writes a byte to the transmit register, which starts an 8-bit full-duplex exchange on the serial pins.

When the exchange ends, a sticky completion flag is set and the byte captured from the slave can be read from the receive register. An interrupt line reports completion when software has enabled it. The flag is cleared by writing a one to it.

The serial side always runs mode 0: SCK idles low, data leaves MSB first and changes while SCK is low, and input is sampled on SCK rising edges. SCK is the system clock divided by four. A self-clearing control bit aborts any exchange and returns the engine and the status flags to their reset state.

Top module: `spi_user_port`

## Requirements
- R1: After reset, control reads 0x08 (only bit 3, the select bit, set), configuration reads 0, status bits 1 (busy) and 0 (done) read 0, cs_n is 1, sck is 0 and irq is 0. Status bit 2 (init) reads 1 from the first clock after reset release.
- R2: Word registers sit at byte offsets 0x00 configuration, 0x04 control, 0x08 status, 0x0C receive data and 0x10 transmit data. Configuration bits [6:0] hold a read-command byte that reads back as written. Control bits [3:0] read back as written: bit 0 is user ownership, bit 1 is interrupt enable, bit 2 is stored with no effect, and bit 3 is the select bit. All other bits read 0.
- R3: The cs_n output equals control bit 3 from the clock edge that writes the control register.
- R4: A transmit write accepted while idle sets status busy from that edge for exactly 32 clocks. The done flag sets on the same edge that busy clears.
- R5: Each exchange makes exactly 8 SCK rising edges, 4 clocks apart. SCK is low outside an exchange, and MOSI never changes while SCK is high. The slave sees the transmit byte MSB first.
- R6: MISO is sampled on SCK rising edges, MSB first. After done, receive register bits [7:0] hold the sampled byte.
- R7: A transmit write is ignored, with no busy and no SCK activity, when control bit 0 is 0 or while an exchange is in progress. In the second case the running exchange is unaffected.
- R8: Writing status with bit 0 set clears done. Writing status with bit 0 clear leaves done unchanged.
- R9: irq is 1 exactly when control bit 1 and done are both 1.
- R10: A control write with bit 4 set aborts any exchange. It clears busy, done and the receive register and drives SCK low. Control bits [3:0] take the written value, and bit 4 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Completion interrupt |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |

## Verification
Forty exchanges use random transmit bytes paired with random slave reply bytes and a random interrupt-enable setting. Because the two directions carry different data, the runs separate bit-order and sampling-edge faults on MOSI and on MISO. Directed all-zero, all-one and alternating patterns expose stuck bits and off-by-one shifts. Further directed cases start a transmit with ownership off, overlap a second transmit write with a running exchange, write zero and one to the done flag, and abort mid-byte. These tell apart gating, priority and clear faults that plain exchanges cannot reveal.

// File: rtl/spiu_pkg.sv
package spiu_pkg;
  // word index of each register (byte offset / 4)
  localparam int IDX_CONF = 0;
  localparam int IDX_CTRL = 1;
  localparam int IDX_STAT = 2;
  localparam int IDX_RXD  = 3;
  localparam int IDX_TXD  = 4;

  // control bit positions
  localparam int CB_SRST = 4;

  // status bit positions
  localparam int SB_DONE = 0;
  localparam int SB_BUSY = 1;
  localparam int SB_INIT = 2;

  localparam int CMD_W  = 7;
  localparam int CTRL_W = 4;

  typedef struct packed {
    logic sel_n;   // bit 3
    logic xaddr;   // bit 2, stored only
    logic ien;     // bit 1
    logic own;     // bit 0
  } ctrl_t;
endpackage

// File: rtl/spiu_shift.sv
module spiu_shift #(
  parameter int BITS = 8,
  parameter int DIV  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [BITS-1:0] tx_byte,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            busy,
  output logic            done_evt,
  output logic [BITS-1:0] rx_byte
);
  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int CNT_W = (BITS > 2) ? $clog2(BITS) : 1;
  localparam logic [DIV_W-1:0] RISE_AT = DIV_W'(DIV/2 - 1);
  localparam logic [DIV_W-1:0] FALL_AT = DIV_W'(DIV - 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(BITS - 1);

  logic             busy_q, busy_d;
  logic             sck_q, sck_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BITS-1:0]  tsr_q, tsr_d;
  logic [BITS-1:0]  rsr_q, rsr_d;
  logic [BITS-1:0]  rxd_q, rxd_d;
  logic             rxd_en;

  assign done_evt = busy_q && (div_q == FALL_AT) && (cnt_q == LAST) && !clr;

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    div_d  = div_q;
    cnt_d  = cnt_q;
    tsr_d  = tsr_q;
    rsr_d  = rsr_q;
    rxd_d  = rxd_q;
    rxd_en = 1'b0;
    if (clr) begin
      busy_d = 1'b0;
      sck_d  = 1'b0;
      div_d  = '0;
      cnt_d  = '0;
      tsr_d  = '0;
      rsr_d  = '0;
      rxd_d  = '0;
      rxd_en = 1'b1;
    end else if (load) begin
      busy_d = 1'b1;
      sck_d  = 1'b0;
      div_d  = '0;
      cnt_d  = '0;
      tsr_d  = tx_byte;
    end else if (busy_q) begin
      div_d = (div_q == FALL_AT) ? '0 : div_q + 1'b1;
      if (div_q == RISE_AT) begin
        sck_d = 1'b1;
        rsr_d = {rsr_q[BITS-2:0], miso};
      end
      if (div_q == FALL_AT) begin
        sck_d = 1'b0;
        if (cnt_q == LAST) begin
          busy_d = 1'b0;
          rxd_d  = rsr_q;
          rxd_en = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
          tsr_d = {tsr_q[BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      div_q  <= '0;
      cnt_q  <= '0;
      tsr_q  <= '0;
      rsr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      tsr_q  <= tsr_d;
      rsr_q  <= rsr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rxd_q <= '0;
    else if (rxd_en) rxd_q <= rxd_d;
  end

  assign sck     = sck_q;
  assign mosi    = tsr_q[BITS-1];
  assign busy    = busy_q;
  assign rx_byte = rxd_q;

  // R5: serial clock stays low whenever no exchange runs
  a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);

  // R5: data out is held for the whole high phase of SCK
  a_r5_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(mosi));
endmodule

// File: rtl/spiu_regs.sv
module spiu_regs
  import spiu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int BITS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_done_evt,
  input  logic [BITS-1:0]   eng_rx,
  output ctrl_t             ctrl,
  output logic              start,
  output logic [BITS-1:0]   tx_byte,
  output logic              soft_rst,
  output logic              done
);
  logic             wr;
  logic             wr_conf, wr_ctrl, wr_stat, wr_txd;
  logic [CMD_W-1:0] conf_q, conf_d;
  ctrl_t            ctrl_q, ctrl_d;
  logic             done_q, done_d;
  logic             init_q;
  logic             conf_en, ctrl_en, done_en;
  logic             unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:BITS];

  assign wr      = bus_sel && bus_we;
  assign wr_conf = wr && (bus_idx == IDX_W'(IDX_CONF));
  assign wr_ctrl = wr && (bus_idx == IDX_W'(IDX_CTRL));
  assign wr_stat = wr && (bus_idx == IDX_W'(IDX_STAT));
  assign wr_txd  = wr && (bus_idx == IDX_W'(IDX_TXD));

  assign soft_rst = wr_ctrl && bus_wdata[CB_SRST];
  assign start    = wr_txd && ctrl_q.own && !eng_busy;
  assign tx_byte  = bus_wdata[BITS-1:0];

  always_comb begin
    conf_en = wr_conf;
    conf_d  = bus_wdata[CMD_W-1:0];
    ctrl_en = wr_ctrl;
    ctrl_d  = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    done_en = 1'b0;
    done_d  = done_q;
    if (soft_rst) begin
      done_en = 1'b1;
      done_d  = 1'b0;
    end else if (eng_done_evt) begin
      done_en = 1'b1;
      done_d  = 1'b1;
    end else if (wr_stat && bus_wdata[SB_DONE]) begin
      done_en = 1'b1;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conf_q <= '0;
      ctrl_q <= '{sel_n: 1'b1, xaddr: 1'b0, ien: 1'b0, own: 1'b0};
      done_q <= 1'b0;
      init_q <= 1'b0;
    end else begin
      if (conf_en) conf_q <= conf_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (done_en) done_q <= done_d;
      init_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_idx)
      IDX_W'(IDX_CONF): bus_rdata[CMD_W-1:0]  = conf_q;
      IDX_W'(IDX_CTRL): bus_rdata[CTRL_W-1:0] = ctrl_q;
      IDX_W'(IDX_STAT): begin
        bus_rdata[SB_DONE] = done_q;
        bus_rdata[SB_BUSY] = eng_busy;
        bus_rdata[SB_INIT] = init_q;
      end
      IDX_W'(IDX_RXD):  bus_rdata[BITS-1:0]   = eng_rx;
      default:          bus_rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign done = done_q;

  // R8: a zero in the done position of a status write never clears the flag
  a_r8_write_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && wr_stat && !bus_wdata[SB_DONE] && !soft_rst) |=> done_q);
endmodule

// File: rtl/spi_user_port.sv
module spi_user_port
  import spiu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int BITS   = 8,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int IDX_W = ADDR_W - 2;

  ctrl_t           ctrl;
  logic            start, soft_rst, done;
  logic            busy, done_evt;
  logic [BITS-1:0] tx_byte, rx_byte;
  logic            unused_lo;

  assign unused_lo = ^bus_addr[1:0];

  spiu_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BITS(BITS)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_idx      (bus_addr[ADDR_W-1:2]),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .eng_busy     (busy),
    .eng_done_evt (done_evt),
    .eng_rx       (rx_byte),
    .ctrl         (ctrl),
    .start        (start),
    .tx_byte      (tx_byte),
    .soft_rst     (soft_rst),
    .done         (done)
  );

  spiu_shift #(.BITS(BITS), .DIV(DIV)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_rst),
    .load     (start),
    .tx_byte  (tx_byte),
    .miso     (miso),
    .sck      (sck),
    .mosi     (mosi),
    .busy     (busy),
    .done_evt (done_evt),
    .rx_byte  (rx_byte)
  );

  assign cs_n = ctrl.sel_n;
  assign irq  = ctrl.ien && done;

  // R7: the register file never restarts a running exchange
  a_r7_no_load_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R4: the end of a normal exchange leaves the done flag set
  a_r4_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(soft_rst)) |-> done);

  // R10: an abort leaves engine idle and flag clear
  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !done && !sck));
endmodule

// File: tb/sim_spi_user_port.sv
module sim_spi_user_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CONF = 5'h00, A_CTRL = 5'h04, A_STAT = 5'h08,
                         A_RXD = 5'h0C, A_TXD = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bsel = 1'b0, bwe = 1'b0;
  logic [4:0]  baddr = '0;
  logic [31:0] bwdata = '0;
  logic [31:0] brdata;
  logic        irq, sck, cs_n, mosi, miso;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // slave model
  logic [7:0] slv_byte = 8'h00;
  logic [7:0] slv_rx = 8'h00;
  int         slv_idx = 0;
  assign miso = (slv_idx < 8) ? slv_byte[3'(7 - slv_idx)] : 1'b0;
  always @(posedge sck) slv_rx <= {slv_rx[6:0], mosi};
  always @(negedge sck) slv_idx <= slv_idx + 1;

  // edge monitor
  int   rises = 0;
  int   last_rise = 0;
  bit   gap_bad = 0, mosi_bad = 0;
  logic sck_p = 1'b0, mosi_p = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_user_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bsel), .bus_we(bwe), .bus_addr(baddr),
    .bus_wdata(bwdata), .bus_rdata(brdata), .irq(irq), .sck(sck),
    .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sck && !sck_p) begin
      if (rises > 0 && (cyc - last_rise) != 4) gap_bad = 1;
      rises = rises + 1;
      last_rise = cyc;
    end
    if (sck && sck_p && mosi !== mosi_p) mosi_bad = 1;
    sck_p = sck;
    mosi_p = mosi;
  end

  function automatic logic [31:0] exp_stat(bit init, bit busy, bit done);
    return {29'b0, init, busy, done};
  endfunction

  function automatic logic [31:0] exp_ctrl(logic [31:0] w);
    return w & 32'h0000_000F;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bsel = 1'b1; bwe = 1'b1; baddr = a; bwdata = d;
    @(negedge clk);
    bsel = 1'b0; bwe = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    baddr = a;
    #1;
    d = brdata;
  endtask

  task automatic arm_slave(logic [7:0] b);
    slv_byte = b;
    slv_idx = 0;
    rises = 0;
    gap_bad = 0;
    mosi_bad = 0;
  endtask

  task automatic wait_idle(output int dur);
    logic [31:0] s;
    dur = 0;
    rd(A_STAT, s);
    while (s[1] && dur < 200) begin
      @(negedge clk);
      dur++;
      rd(A_STAT, s);
    end
  endtask

  task automatic xfer_check(logic [7:0] tx, logic [7:0] sb, bit ien);
    int dur;
    logic [31:0] v;
    wr(A_CTRL, {30'b0, ien, 1'b1});
    arm_slave(sb);
    wr(A_TXD, {24'b0, tx});
    wait_idle(dur);
    chk("R4 busy length", 32'(dur), 32'd32);
    rd(A_STAT, v);
    chk("R4 done after exchange", v, exp_stat(1, 0, 1));
    chk("R5 slave got tx byte", {24'b0, slv_rx}, {24'b0, tx});
    chk("R5 eight rising edges", 32'(rises), 32'd8);
    chk("R5 sck period and mosi hold", {30'b0, gap_bad, mosi_bad}, 32'd0);
    chk("R5 sck idle low", {31'b0, sck}, 32'd0);
    rd(A_RXD, v);
    chk("R6 rx byte", v, {24'b0, sb});
    chk("R9 irq with done", {31'b0, irq}, {31'b0, ien});
    wr(A_STAT, 32'h1);
    rd(A_STAT, v);
    chk("R8 w1c clears done", v, exp_stat(1, 0, 0));
    chk("R9 irq after clear", {31'b0, irq}, 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int dur;
    void'($urandom(32'd7171));
    repeat (3) @(negedge clk);
    // R1 reset state before release
    chk("R1 cs_n reset", {31'b0, cs_n}, 32'd1);
    chk("R1 sck reset", {31'b0, sck}, 32'd0);
    chk("R1 irq reset", {31'b0, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(A_CTRL, v); chk("R1 ctrl reset", v, 32'h8);
    rd(A_CONF, v); chk("R1 conf reset", v, 32'h0);
    rd(A_STAT, v); chk("R1 status reset init", v, exp_stat(1, 0, 0));
    rd(A_RXD, v);  chk("R2 rx reset", v, 32'h0);

    // R2 readback and masking
    wr(A_CONF, 32'hFFFF_FFEB);
    rd(A_CONF, v); chk("R2 conf readback", v, 32'h6B);
    wr(A_CTRL, 32'hFFFF_FFE6);
    rd(A_CTRL, v); chk("R2 ctrl readback", v, exp_ctrl(32'hFFFF_FFE6));
    chk("R3 cs_n follows bit3 clear", {31'b0, cs_n}, 32'd0);
    rd(5'h14, v);  chk("R2 unmapped reads zero", v, 32'h0);
    wr(A_CTRL, 32'h8);
    chk("R3 cs_n follows bit3 set", {31'b0, cs_n}, 32'd1);

    // R7 transmit without ownership
    arm_slave(8'hFF);
    wr(A_TXD, 32'hA5);
    repeat (40) @(negedge clk);
    rd(A_STAT, v); chk("R7 no start without own", v, exp_stat(1, 0, 0));
    chk("R7 no sck without own", 32'(rises), 32'd0);

    // directed patterns
    xfer_check(8'h00, 8'hFF, 1'b1);
    xfer_check(8'hFF, 8'h00, 1'b0);
    xfer_check(8'hAA, 8'h55, 1'b1);
    xfer_check(8'h81, 8'h7E, 1'b1);

    // R8 write of zero keeps done
    wr(A_CTRL, 32'h3);
    arm_slave(8'h3C);
    wr(A_TXD, 32'hC3);
    wait_idle(dur);
    wr(A_STAT, 32'hFFFF_FFFE);
    rd(A_STAT, v); chk("R8 write zero keeps done", v, exp_stat(1, 0, 1));
    chk("R9 irq held", {31'b0, irq}, 32'd1);
    wr(A_CTRL, 32'h1);
    chk("R9 irq off when disabled", {31'b0, irq}, 32'd0);
    wr(A_STAT, 32'h1);

    // R7 transmit write during exchange
    arm_slave(8'h96);
    wr(A_TXD, 32'h5A);
    repeat (5) @(negedge clk);
    wr(A_TXD, 32'h0F);
    wait_idle(dur);
    chk("R7 busy write no restart", 32'(dur), 32'd25);
    chk("R7 slave got first byte", {24'b0, slv_rx}, 32'h5A);
    chk("R7 eight edges only", 32'(rises), 32'd8);
    rd(A_RXD, v); chk("R7 rx of first exchange", v, 32'h96);
    wr(A_STAT, 32'h1);

    // R10 abort mid exchange
    arm_slave(8'hE7);
    wr(A_TXD, 32'h24);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'h17);
    rd(A_STAT, v); chk("R10 abort clears flags", v, exp_stat(1, 0, 0));
    rd(A_RXD, v);  chk("R10 abort clears rx", v, 32'h0);
    rd(A_CTRL, v); chk("R10 ctrl after abort", v, 32'h7);
    chk("R10 sck low after abort", {31'b0, sck}, 32'd0);
    rises = 0;
    repeat (20) @(negedge clk);
    chk("R10 engine stays idle", 32'(rises), 32'd0);

    // random exchanges
    for (int i = 0; i < 40; i++) begin
      xfer_check(8'($urandom), 8'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule